// File: doc/BRIEF.md
# Clock Phase Generator with Selectable Double Speed

This block derives the core timing of a small controller from a single oscillator clock. A divide-by-two stage sits between the oscillator and a six-state phase sequencer. One control bit selects how that stage is used. In standard speed it halves the rate. In double speed it is bypassed, so the sequencer advances on every oscillator cycle. A machine cycle is always six core periods: twelve oscillator periods in standard speed and six in double speed.

The block produces no derived clock. It emits a core clock enable that the rest of the core qualifies its registers with, and the phase index of the current machine cycle. It also drives an address latch pulse train with two pulses per machine cycle. A flag from the instruction sequencer marks machine cycles that access external data memory. The second address latch pulse of each such cycle is suppressed.

A write to the speed bit is not applied at once. It is held until the next rising edge of the divided clock. This keeps every enable gap in standard speed exactly one oscillator cycle long across the switch.

Top module: `clkphase_gen`

## Requirements
- R1: While reset is held, phase is 0, core_en is low, cfg_rdata is 0 and standard speed is selected. On the first oscillator edge after release the divided clock rises, so core_en is high in the first cycle after release.
- R2: In standard speed core_en is high on every second oscillator cycle: 6 enabled cycles in any 12 consecutive cycles, giving 12 oscillator periods per machine cycle.
- R3: In double speed core_en is high on every oscillator cycle, giving 6 oscillator periods per machine cycle.
- R4: phase counts 0,1,2,3,4,5,0,… and advances only on edges where core_en was high. It holds its value otherwise.
- R5: A new speed value takes effect only at an oscillator edge where the divided clock rises, that is, where its toggle flop goes from 0 to 1. In standard speed no two consecutive cycles are both enabled or both idle, including around a switch.
- R6: ale is high while phase is 0 and while phase is 3. Its rate is 1/6 of the oscillator frequency in standard speed (2 rising edges per 12 cycles) and 1/3 in double speed (4 per 12).
- R7: xdata_cycle is sampled on the enabled edge that ends phase 5. When it is sampled high, the phase-3 ale pulse of the machine cycle that follows is suppressed. A low sample restores it for the next machine cycle.
- R8: The speed request is bit 0 of the control register (1 selects double speed). A write with cfg_wr high loads it at that edge, and cfg_rdata shows it from then on. Bits 7 to 1 read as 0, and values written to them are ignored.
- R9: When cfg_wr is low, cfg_wdata has no effect on the readback or on the speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Control register write data; bit 0 requests double speed |
| cfg_rdata | output | 8 | Control register readback; reserved bits read 0 |
| xdata_cycle | input | 1 | Marks the next machine cycle as an external data access |
| core_en | output | 1 | Core clock enable, one oscillator cycle wide per core period |
| phase | output | 3 | Phase index within the machine cycle, 0 to 5 |
| ale | output | 1 | Address latch enable pulse train |

## Verification
Two functions can meet on one oscillator edge. A speed write can land on the edge where the divided clock rises, and the pending speed change can be applied on the same edge that closes phase 5 and samples xdata_cycle. The bench sweeps the write across both parities of the divide-by-two flop and toggles xdata_cycle during the switches. A behavioural model counts oscillator ticks and predicts the enable, phase, pulse and readback. That prediction is compared with the outputs in every cycle, which shows whether the write was deferred by the right number of edges and whether the skipped pulse belongs to the correct machine cycle.

// File: rtl/clkphase_pkg.sv
package clkphase_pkg;

   // index width for a counter that holds values 0 .. n-1
   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   typedef enum logic {
      SPEED_STD = 1'b0,
      SPEED_DBL = 1'b1
   } speed_e;

endpackage

// File: rtl/cgen_cfg.sv
// Control register: one speed request bit, all other bits reserved.
module cgen_cfg #(
   parameter int unsigned CFG_W    = 8,
   parameter int unsigned MODE_BIT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] wdata,
   output logic             req,
   output logic [CFG_W-1:0] rdata
);

   logic req_q;
   logic unused_rsvd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  req_q <= 1'b0;
      else if (wr) req_q <= wdata[MODE_BIT];
   end

   assign req         = req_q;
   assign unused_rsvd = ^wdata;

   for (genvar b = 0; b < CFG_W; b++) begin : g_rd
      if (b == MODE_BIT) begin : g_mode
         assign rdata[b] = req_q;
      end else begin : g_rsvd
         assign rdata[b] = 1'b0;
      end
   end

endmodule

// File: rtl/cgen_div.sv
// Divide-by-two toggle and speed selection, expressed as a clock enable.
module cgen_div
   import clkphase_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic div_q,
   output logic x2_act,
   output logic core_en
);

   logic   tog_q;
   speed_e speed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q   <= 1'b0;
         speed_q <= SPEED_STD;
      end else begin
         tog_q <= ~tog_q;
         // the divided clock rises on this edge: apply the pending request
         if (!tog_q) speed_q <= speed_e'(req);
      end
   end

   assign div_q   = tog_q;
   assign x2_act  = (speed_q == SPEED_DBL);
   assign core_en = x2_act | tog_q;

endmodule

// File: rtl/cgen_seq.sv
// Machine-cycle phase counter and address latch pulse generation.
module cgen_seq #(
   parameter int unsigned PHASES     = 6,
   parameter int unsigned PH_W       = 3,
   parameter int unsigned ALE_A      = 0,
   parameter int unsigned ALE_B      = 3,
   parameter int unsigned SKIP_PULSE = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            core_en,
   input  logic            xdata_cycle,
   output logic [PH_W-1:0] phase,
   output logic            skip,
   output logic            ale
);

   localparam logic [PH_W-1:0] LAST  = PH_W'(PHASES - 1);
   localparam logic [PH_W-1:0] PH_A  = PH_W'(ALE_A);
   localparam logic [PH_W-1:0] PH_B  = PH_W'(ALE_B);

   logic [PH_W-1:0] phase_q;
   logic            skip_q;
   logic            hit_a;
   logic            hit_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         skip_q  <= 1'b0;
      end else if (core_en) begin
         if (phase_q == LAST) begin
            phase_q <= '0;
            skip_q  <= xdata_cycle;
         end else begin
            phase_q <= phase_q + PH_W'(1);
         end
      end
   end

   assign hit_a = (phase_q == PH_A);
   assign hit_b = (phase_q == PH_B);

   if (SKIP_PULSE == 1) begin : g_skip_second
      assign ale = hit_a | (hit_b & ~skip_q);
   end else begin : g_skip_first
      assign ale = (hit_a & ~skip_q) | hit_b;
   end

   assign phase = phase_q;
   assign skip  = skip_q;

endmodule

// File: rtl/clkphase_gen.sv
module clkphase_gen
   import clkphase_pkg::*;
#(
   parameter int unsigned CFG_W      = 8,
   parameter int unsigned MODE_BIT   = 0,
   parameter int unsigned PHASES     = 6,
   parameter int unsigned ALE_A      = 0,
   parameter int unsigned ALE_B      = 3,
   parameter int unsigned SKIP_PULSE = 1,
   localparam int unsigned PH_W      = idx_w(PHASES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic             xdata_cycle,
   output logic             core_en,
   output logic [PH_W-1:0]  phase,
   output logic             ale
);

   if (MODE_BIT >= CFG_W) begin : g_bad_mode_bit
      $error("MODE_BIT must lie inside the control register");
   end
   if (PHASES < 2) begin : g_bad_phases
      $error("PHASES must be at least 2");
   end
   if (ALE_A >= PHASES || ALE_B >= PHASES || ALE_A == ALE_B) begin : g_bad_ale
      $error("ALE phases must be distinct and below PHASES");
   end
   if (SKIP_PULSE > 1) begin : g_bad_skip
      $error("SKIP_PULSE selects pulse 0 or 1");
   end

   logic req;
   logic div_q;
   logic x2_act;
   logic skip_q;

   cgen_cfg #(
      .CFG_W    (CFG_W),
      .MODE_BIT (MODE_BIT)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .req   (req),
      .rdata (cfg_rdata)
   );

   cgen_div u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .div_q   (div_q),
      .x2_act  (x2_act),
      .core_en (core_en)
   );

   cgen_seq #(
      .PHASES     (PHASES),
      .PH_W       (PH_W),
      .ALE_A      (ALE_A),
      .ALE_B      (ALE_B),
      .SKIP_PULSE (SKIP_PULSE)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .core_en     (core_en),
      .xdata_cycle (xdata_cycle),
      .phase       (phase),
      .skip        (skip_q),
      .ale         (ale)
   );

endmodule

// File: rtl/clkphase_gen_chk.sv
module clkphase_gen_chk
   import clkphase_pkg::*;
#(
   parameter int unsigned CFG_W      = 8,
   parameter int unsigned MODE_BIT   = 0,
   parameter int unsigned PHASES     = 6,
   parameter int unsigned ALE_B      = 3,
   parameter int unsigned SKIP_PULSE = 1,
   localparam int unsigned PH_W      = idx_w(PHASES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             core_en,
   input logic [PH_W-1:0]  phase,
   input logic             ale,
   input logic [CFG_W-1:0] cfg_rdata,
   input logic             x2_act,
   input logic             div_q,
   input logic             skip
);

   localparam logic [PH_W-1:0]  LAST   = PH_W'(PHASES - 1);
   localparam logic [PH_W-1:0]  PH_B   = PH_W'(ALE_B);
   localparam logic [CFG_W-1:0] RSVD_M = ~(CFG_W'(1) << MODE_BIT);

   AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= LAST); // R4

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      core_en |=> (phase == (($past(phase) == LAST) ? '0 : $past(phase) + PH_W'(1)))); // R4

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !core_en |=> $stable(phase)); // R4

   AST_STD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!x2_act && core_en) |=> !core_en); // R2

   AST_STD_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!x2_act && !core_en) |=> core_en); // R5

   AST_DBL_CONTINUOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (x2_act && $past(x2_act)) |-> (core_en && $past(core_en))); // R3

   AST_MODE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(x2_act) |-> !$past(div_q)); // R5

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & RSVD_M) == '0); // R8

   AST_SKIP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (SKIP_PULSE == 1 && skip && phase == PH_B) |-> !ale); // R7

endmodule

bind clkphase_gen clkphase_gen_chk #(
   .CFG_W      (CFG_W),
   .MODE_BIT   (MODE_BIT),
   .PHASES     (PHASES),
   .ALE_B      (ALE_B),
   .SKIP_PULSE (SKIP_PULSE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .core_en   (core_en),
   .phase     (phase),
   .ale       (ale),
   .cfg_rdata (cfg_rdata),
   .x2_act    (x2_act),
   .div_q     (div_q),
   .skip      (skip_q)
);

// File: tb/clkphase_gen_test.sv
`timescale 1ns/1ps
module clkphase_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       xdata_cycle = 1'b0;
   logic [7:0] cfg_rdata;
   logic       core_en;
   logic [2:0] phase;
   logic       ale;

   int checks = 0;
   int fails  = 0;
   bit cmp_on = 1'b0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   clkphase_gen uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr      (cfg_wr),
      .cfg_wdata   (cfg_wdata),
      .cfg_rdata   (cfg_rdata),
      .xdata_cycle (xdata_cycle),
      .core_en     (core_en),
      .phase       (phase),
      .ale         (ale)
   );

   // behavioural reference: oscillator tick parity, pending/active speed,
   // machine-cycle state count and the external-access mark
   bit m_half, m_req, m_fast, m_skip;
   int m_state;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_half = 0; m_req = 0; m_fast = 0; m_skip = 0; m_state = 0;
      end else begin
         bit tick;
         tick = m_fast || m_half;
         if (tick) begin
            if (m_state == 5) begin
               m_state = 0;
               m_skip  = xdata_cycle;
            end else begin
               m_state = m_state + 1;
            end
         end
         if (!m_half) m_fast = m_req;
         if (cfg_wr)  m_req  = cfg_wdata[0];
         m_half = !m_half;
      end
   end

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         bit e_en, e_ale;
         e_en  = m_fast || m_half;
         e_ale = (m_state == 0) || (m_state == 3 && !m_skip);
         chk(core_en == e_en, "R2 R3 R5 core_en", core_en, e_en);
         chk(int'(phase) == m_state, "R4 phase", phase, m_state);
         chk(ale == e_ale, "R6 R7 ale", ale, e_ale);
         chk(cfg_rdata == {7'b0, m_req}, "R8 R9 cfg_rdata", cfg_rdata, {7'b0, m_req});
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_wr    = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_wr    = 1'b0;
   endtask

   // counts enabled cycles over n samples and ale rising edges over n transitions
   task automatic window(input int n, output int en_cnt, output int rises);
      bit prev;
      en_cnt = 0;
      rises  = 0;
      @(negedge clk);
      prev = ale;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (core_en) en_cnt++;
         if (ale && !prev) rises++;
         prev = ale;
      end
   endtask

   initial begin
      int en_cnt, rises;
      #2 rst_n = 1'b0;
      cmp_on = 1'b1;
      // R1: reset state
      wait_n(3);
      chk(phase == 3'd0, "R1 reset phase", phase, 0);
      chk(core_en == 1'b0, "R1 reset core_en", core_en, 0);
      chk(cfg_rdata == 8'h00, "R1 reset cfg_rdata", cfg_rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(core_en == 1'b1 && phase == 3'd0, "R1 first enable", {phase, core_en}, 1);
      @(negedge clk);
      chk(core_en == 1'b0 && phase == 3'd1, "R1 second cycle", {phase, core_en}, 2);

      // R2 R6: standard speed rates
      wait_n(20);
      window(12, en_cnt, rises);
      chk(en_cnt == 6, "R2 enables per 12 cycles", en_cnt, 6);
      chk(rises == 2, "R6 ale rises per 12 cycles std", rises, 2);

      // R9: data without strobe
      cfg_wdata = 8'hFF;
      wait_n(20);
      chk(cfg_rdata == 8'h00, "R9 readback without strobe", cfg_rdata, 0);
      window(12, en_cnt, rises);
      chk(en_cnt == 6, "R9 speed unchanged", en_cnt, 6);
      cfg_wdata = 8'h00;

      // R8 R3 R6: double speed
      write_cfg(8'h01);
      chk(cfg_rdata == 8'h01, "R8 readback after write", cfg_rdata, 1);
      wait_n(4);
      window(12, en_cnt, rises);
      chk(en_cnt == 12, "R3 enables per 12 cycles", en_cnt, 12);
      chk(rises == 4, "R6 ale rises per 12 cycles dbl", rises, 4);

      // R8: reserved bits ignored, speed bit cleared
      write_cfg(8'hFE);
      chk(cfg_rdata == 8'h00, "R8 reserved bits read zero", cfg_rdata, 0);
      wait_n(4);
      window(12, en_cnt, rises);
      chk(en_cnt == 6, "R8 back to standard", en_cnt, 6);

      // R5: switch at every offset relative to the divider, with xdata toggling
      for (int off = 0; off < 4; off++) begin
         wait_n(off);
         xdata_cycle = off[0];
         write_cfg(8'h01);
         wait_n(9 + off);
         xdata_cycle = ~off[0];
         write_cfg(8'h00);
         wait_n(11);
      end
      xdata_cycle = 1'b0;

      // R7: every machine cycle marked external
      xdata_cycle = 1'b1;
      wait_n(30);
      window(24, en_cnt, rises);
      chk(rises == 2, "R7 ale rises per 24 cycles with skip", rises, 2);
      xdata_cycle = 1'b0;
      wait_n(30);
      window(24, en_cnt, rises);
      chk(rises == 4, "R7 pulses restored", rises, 4);

      // R7 R3: sparse external marks in double speed
      write_cfg(8'h01);
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         xdata_cycle = (i % 7 == 2) || (i % 11 == 5);
      end
      xdata_cycle = 1'b0;
      wait_n(12);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule